// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This unit sits beside a UART channel that has deep receive and transmit FIFOs. It holds back the remote sender in two ways. Out of band, it drives the RTS# and DTR# pins from a hysteresis comparison of the receive FIFO level. In band, it queues XOFF and XON characters for the transmitter. In the other direction, it decides when the local transmitter may start a new character. That decision depends on the CTS# and DSR# inputs and on XON/XOFF characters found in the received stream.

The unit also raises a special-character interrupt, which a read of the interrupt status register clears. It can turn DTR# into a line-driver enable for half-duplex RS485 links, and it has a loopback mode. The serializer is outside the block. At every character boundary the serializer asks whether it may start a queued data byte or must send an inserted flow character instead.

Top module: `uart_flowctl`

## Requirements
- R1: An internal throttle state becomes 1 on the clock edge after the receive level is at or above the upper threshold. Once set, it stays 1 until the level is strictly below the lower threshold, and it returns to 0 on the edge that follows.
- R2: Outside loopback, with automatic RTS enabled, rts_n equals the throttle state (1 means hold off) and mcr_rts has no effect. With automatic RTS disabled, rts_n is the inverse of mcr_rts.
- R3: Automatic DTR has its own enable and follows the same throttle state on dtr_n, whatever the RTS settings are. With it disabled and RS485 mode off, dtr_n is the inverse of mcr_dtr.
- R4: A data character starts (tx_start_data=1) only when tx_boundary=1 and tx_data_avail=1. It does not start while cts_n=1 with automatic CTS enabled, or while dsr_n=1 with automatic DSR enabled. Either input is ignored when its enable is 0.
- R5: With in-band receive control enabled, a received character equal to the XOFF register stops data starts from the next cycle. A received character equal to the XON register resumes them.
- R6: With XON-any also enabled, any received character other than XOFF resumes a transmitter stopped by XOFF.
- R7: irq_special goes to 1 in either of two cases: after a received XOFF while in-band receive control is enabled, or after a character that matches the second XOFF register while special detection is enabled. A pulse on isr_read clears it. Nothing else raises it.
- R8: With in-band transmit control enabled, a 0-to-1 change of the throttle state queues the XOFF character and a 1-to-0 change queues XON. The flow character is offered on tx_ins_valid/tx_ins_char one cycle after the throttle change, at the next boundary where CTS/DSR allow it. A queued flow character blocks tx_start_data until it has been sent.
- R9: In RS485 mode, dtr_n goes to 0 on the cycle after a character starts. It stays 0 until tx_empty=1 and sout_idle=1 together, and it returns to 1 one cycle after that.
- R10: In loopback mode, rts_n and dtr_n are held at 1 and rx_held_off reports the internal throttle state. Outside loopback, rx_held_off reports the value that the RTS logic drives to the pin.
- R11: After reset the throttle state is 0, the transmitter is not stopped, irq_special is 0 and no flow character is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_auto_rts | input | 1 | Enable automatic RTS from the receive level |
| cfg_auto_dtr | input | 1 | Enable automatic DTR from the receive level |
| cfg_auto_cts | input | 1 | Gate the transmitter on CTS# |
| cfg_auto_dsr | input | 1 | Gate the transmitter on DSR# |
| cfg_inband_rx | input | 1 | Act on XON/XOFF found in the received stream |
| cfg_inband_tx | input | 1 | Insert XON/XOFF into the transmit stream |
| cfg_xon_any | input | 1 | Any received character resumes a stopped transmitter |
| cfg_special_en | input | 1 | Enable matching against the second XOFF character |
| cfg_rs485 | input | 1 | DTR# acts as the line-driver enable |
| cfg_loopback | input | 1 | Loopback mode |
| cfg_xon_char | input | 8 | XON character |
| cfg_xoff_char | input | 8 | XOFF character |
| cfg_xoff2_char | input | 8 | Second XOFF (special) character |
| cfg_hi_thr | input | LVL_W | Upper receive-level threshold |
| cfg_lo_thr | input | LVL_W | Lower receive-level threshold |
| mcr_rts | input | 1 | Manual RTS request (1 = assert) |
| mcr_dtr | input | 1 | Manual DTR request (1 = assert) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_strobe | input | 1 | A received character is valid this cycle |
| rx_data | input | 8 | Received character |
| isr_read | input | 1 | Interrupt status register is being read |
| cts_n | input | 1 | CTS# pin |
| dsr_n | input | 1 | DSR# pin |
| tx_boundary | input | 1 | Serializer can start a new character this cycle |
| tx_data_avail | input | 1 | A data byte is queued for transmission |
| tx_empty | input | 1 | Transmitter holds no data |
| sout_idle | input | 1 | Serial output is at the marking level |
| rts_n | output | 1 | RTS# pin |
| dtr_n | output | 1 | DTR# pin |
| tx_start_data | output | 1 | Start the queued data byte now |
| tx_ins_valid | output | 1 | Send tx_ins_char now instead of data |
| tx_ins_char | output | 8 | Flow character to insert |
| irq_special | output | 1 | Special-character interrupt |
| rx_held_off | output | 1 | Flow status: remote sender is being held off |

## Verification
The bench walks the receive level through the hysteresis band: just under the upper threshold, exactly on it, inside the band, exactly on the lower threshold and one below. A design that compared with the wrong inequality, or that released at the lower threshold, would move RTS# one step early or late.

Several corner cases target the transmit side. An inserted XOFF is made to wait at a boundary where a data byte is also ready; a design that lacked the priority would start the data byte, and one that dropped the queue would never offer XON. RS485 release is tested with the transmitter empty but the line not yet idle, where a careless design would cut the driver in the middle of the stop bit. Loopback is tested with the physical RTS# and the internal throttle state disagreeing, so a status bit that was wired to the pin would show the wrong value.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int CHAR_W = 8;
    typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/fc_hyst.sv
module fc_hyst #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] hi_thr,
    input  logic [LVL_W-1:0] lo_thr,
    output logic             throttle
);
    typedef struct packed {
        logic thr;
    } hyst_st_t;

    hyst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (level >= hi_thr)
            st_d.thr = 1'b1;
        else if (level < lo_thr)
            st_d.thr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign throttle = st_q.thr;

    assert_set_at_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= hi_thr) |=> throttle);
    assert_hold_in_band_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle && level >= lo_thr) |=> throttle);
endmodule

// File: rtl/fc_inband_rx.sv
module fc_inband_rx
    import fc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inband_en,
    input  logic  xon_any,
    input  logic  special_en,
    input  char_t xon_char,
    input  char_t xoff_char,
    input  char_t xoff2_char,
    input  logic  rx_strobe,
    input  char_t rx_data,
    input  logic  isr_read,
    output logic  stopped,
    output logic  irq
);
    typedef struct packed {
        logic stop;
        logic irq;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   hit_xoff, hit_xon, hit_any, hit_special;

    always_comb begin
        hit_xoff    = rx_strobe && inband_en && (rx_data == xoff_char);
        hit_xon     = rx_strobe && inband_en && (rx_data == xon_char);
        hit_any     = rx_strobe && inband_en && xon_any;
        hit_special = rx_strobe && special_en && (rx_data == xoff2_char);

        st_d = st_q;
        if (!inband_en)
            st_d.stop = 1'b0;
        else if (hit_xoff)
            st_d.stop = 1'b1;
        else if (hit_xon || hit_any)
            st_d.stop = 1'b0;

        if (isr_read)
            st_d.irq = 1'b0;
        if (hit_xoff || hit_special)
            st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stopped = st_q.stop;
    assign irq     = st_q.irq;

    assert_xoff_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && inband_en && rx_data == xoff_char) |=> stopped);
    assert_xon_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && inband_en && xon_any && rx_data != xoff_char) |=> !stopped);
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_read && !rx_strobe) |=> !irq);
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !rx_strobe) |=> !irq);
endmodule

// File: rtl/fc_ins.sv
module fc_ins
    import fc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inband_tx_en,
    input  logic  throttle,
    input  char_t xon_char,
    input  char_t xoff_char,
    input  logic  tx_boundary,
    input  logic  oob_ok,
    output logic  ins_pend,
    output logic  ins_fire,
    output char_t ins_char
);
    typedef struct packed {
        logic  prev;
        logic  pend;
        char_t chr;
    } ins_st_t;

    ins_st_t st_d, st_q;
    logic    fire;

    always_comb begin
        fire = st_q.pend && tx_boundary && oob_ok;
        st_d = st_q;
        st_d.prev = throttle;
        if (fire)
            st_d.pend = 1'b0;
        if (inband_tx_en && (throttle != st_q.prev)) begin
            st_d.pend = 1'b1;
            st_d.chr  = throttle ? xoff_char : xon_char;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ins_pend = st_q.pend;
    assign ins_fire = fire;
    assign ins_char = st_q.chr;

    assert_queue_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_pend && !tx_boundary) |=> ins_pend);
    assert_fire_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_fire |-> (tx_boundary && ins_pend));
endmodule

// File: rtl/fc_txgate.sv
module fc_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_cts,
    input  logic auto_dsr,
    input  logic cts_n,
    input  logic dsr_n,
    input  logic stopped,
    input  logic ins_pend,
    input  logic ins_fire,
    input  logic tx_boundary,
    input  logic tx_data_avail,
    input  logic tx_empty,
    input  logic sout_idle,
    output logic oob_ok,
    output logic tx_start,
    output logic drv_en
);
    typedef struct packed {
        logic drv;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        oob_ok   = (!auto_cts || !cts_n) && (!auto_dsr || !dsr_n);
        tx_start = tx_boundary && tx_data_avail && oob_ok && !stopped && !ins_pend;
        st_d = st_q;
        if (tx_start || ins_fire)
            st_d.drv = 1'b1;
        else if (tx_empty && sout_idle)
            st_d.drv = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drv_en = st_q.drv;

    assert_cts_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts && cts_n) |-> !tx_start);
    assert_data_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_pend |-> !tx_start);
    assert_driver_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !(tx_empty && sout_idle)) |=> drv_en);
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
    import fc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_auto_rts,
    input  logic             cfg_auto_dtr,
    input  logic             cfg_auto_cts,
    input  logic             cfg_auto_dsr,
    input  logic             cfg_inband_rx,
    input  logic             cfg_inband_tx,
    input  logic             cfg_xon_any,
    input  logic             cfg_special_en,
    input  logic             cfg_rs485,
    input  logic             cfg_loopback,
    input  logic [7:0]       cfg_xon_char,
    input  logic [7:0]       cfg_xoff_char,
    input  logic [7:0]       cfg_xoff2_char,
    input  logic [LVL_W-1:0] cfg_hi_thr,
    input  logic [LVL_W-1:0] cfg_lo_thr,
    input  logic             mcr_rts,
    input  logic             mcr_dtr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_strobe,
    input  logic [7:0]       rx_data,
    input  logic             isr_read,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             tx_boundary,
    input  logic             tx_data_avail,
    input  logic             tx_empty,
    input  logic             sout_idle,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             tx_start_data,
    output logic             tx_ins_valid,
    output logic [7:0]       tx_ins_char,
    output logic             irq_special,
    output logic             rx_held_off
);
    logic  throttle, stopped, ins_pend, ins_fire, oob_ok, drv_en;
    logic  rts_core, dtr_core;
    char_t ins_char;

    fc_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk(clk), .rst_n(rst_n), .level(rx_level),
        .hi_thr(cfg_hi_thr), .lo_thr(cfg_lo_thr), .throttle(throttle)
    );

    fc_inband_rx u_inrx (
        .clk(clk), .rst_n(rst_n), .inband_en(cfg_inband_rx), .xon_any(cfg_xon_any),
        .special_en(cfg_special_en), .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char),
        .xoff2_char(cfg_xoff2_char), .rx_strobe(rx_strobe), .rx_data(rx_data),
        .isr_read(isr_read), .stopped(stopped), .irq(irq_special)
    );

    fc_ins u_ins (
        .clk(clk), .rst_n(rst_n), .inband_tx_en(cfg_inband_tx), .throttle(throttle),
        .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char), .tx_boundary(tx_boundary),
        .oob_ok(oob_ok), .ins_pend(ins_pend), .ins_fire(ins_fire), .ins_char(ins_char)
    );

    fc_txgate u_gate (
        .clk(clk), .rst_n(rst_n), .auto_cts(cfg_auto_cts), .auto_dsr(cfg_auto_dsr),
        .cts_n(cts_n), .dsr_n(dsr_n), .stopped(stopped), .ins_pend(ins_pend),
        .ins_fire(ins_fire), .tx_boundary(tx_boundary), .tx_data_avail(tx_data_avail),
        .tx_empty(tx_empty), .sout_idle(sout_idle), .oob_ok(oob_ok),
        .tx_start(tx_start_data), .drv_en(drv_en)
    );

    always_comb begin
        rts_core = cfg_auto_rts ? throttle : !mcr_rts;
        if (cfg_rs485)
            dtr_core = !drv_en;
        else
            dtr_core = cfg_auto_dtr ? throttle : !mcr_dtr;
        rts_n       = cfg_loopback ? 1'b1 : rts_core;
        dtr_n       = cfg_loopback ? 1'b1 : dtr_core;
        rx_held_off = cfg_loopback ? throttle : rts_core;
    end

    assign tx_ins_valid = ins_fire;
    assign tx_ins_char  = ins_char;

    assert_loop_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_loopback |-> (rts_n && dtr_n));
    assert_one_char_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tx_start_data, tx_ins_valid}) <= 1);
endmodule

// File: tb/uart_flowctl_bench.sv
module uart_flowctl_bench;
    localparam int LVL_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto_rts, cfg_auto_dtr, cfg_auto_cts, cfg_auto_dsr;
    logic cfg_inband_rx, cfg_inband_tx, cfg_xon_any, cfg_special_en;
    logic cfg_rs485, cfg_loopback;
    logic [7:0] cfg_xon_char, cfg_xoff_char, cfg_xoff2_char;
    logic [LVL_W-1:0] cfg_hi_thr, cfg_lo_thr, rx_level;
    logic mcr_rts, mcr_dtr, rx_strobe, isr_read, cts_n, dsr_n;
    logic [7:0] rx_data;
    logic tx_boundary, tx_data_avail, tx_empty, sout_idle;
    logic rts_n, dtr_n, tx_start_data, tx_ins_valid, irq_special, rx_held_off;
    logic [7:0] tx_ins_char;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_flowctl #(.LVL_W(LVL_W)) u_uart_flowctl (
        .clk(clk), .rst_n(rst_n),
        .cfg_auto_rts(cfg_auto_rts), .cfg_auto_dtr(cfg_auto_dtr),
        .cfg_auto_cts(cfg_auto_cts), .cfg_auto_dsr(cfg_auto_dsr),
        .cfg_inband_rx(cfg_inband_rx), .cfg_inband_tx(cfg_inband_tx),
        .cfg_xon_any(cfg_xon_any), .cfg_special_en(cfg_special_en),
        .cfg_rs485(cfg_rs485), .cfg_loopback(cfg_loopback),
        .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
        .cfg_xoff2_char(cfg_xoff2_char), .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr),
        .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr), .rx_level(rx_level),
        .rx_strobe(rx_strobe), .rx_data(rx_data), .isr_read(isr_read),
        .cts_n(cts_n), .dsr_n(dsr_n), .tx_boundary(tx_boundary),
        .tx_data_avail(tx_data_avail), .tx_empty(tx_empty), .sout_idle(sout_idle),
        .rts_n(rts_n), .dtr_n(dtr_n), .tx_start_data(tx_start_data),
        .tx_ins_valid(tx_ins_valid), .tx_ins_char(tx_ins_char),
        .irq_special(irq_special), .rx_held_off(rx_held_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic defaults();
        cfg_auto_rts = 0; cfg_auto_dtr = 0; cfg_auto_cts = 0; cfg_auto_dsr = 0;
        cfg_inband_rx = 0; cfg_inband_tx = 0; cfg_xon_any = 0; cfg_special_en = 0;
        cfg_rs485 = 0; cfg_loopback = 0;
        cfg_xon_char = 8'h11; cfg_xoff_char = 8'h13; cfg_xoff2_char = 8'h7E;
        cfg_hi_thr = 8'd100; cfg_lo_thr = 8'd40; rx_level = 8'd0;
        mcr_rts = 0; mcr_dtr = 0; rx_strobe = 0; rx_data = 8'h00; isr_read = 0;
        cts_n = 0; dsr_n = 0; tx_boundary = 0; tx_data_avail = 0;
        tx_empty = 1; sout_idle = 1;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk); @(negedge clk);
    endtask

    task automatic set_level(input logic [7:0] v);
        @(negedge clk); rx_level = v;
        @(negedge clk); #1;
    endtask

    task automatic send_rx(input logic [7:0] c);
        @(negedge clk); rx_strobe = 1; rx_data = c;
        @(negedge clk); rx_strobe = 0; #1;
    endtask

    task automatic pulse_isr();
        @(negedge clk); isr_read = 1;
        @(negedge clk); isr_read = 0; #1;
    endtask

    task automatic t_reset();
        #1;
        check("R11 rts_n idle", rts_n, 1);
        check("R11 dtr_n idle", dtr_n, 1);
        check("R11 irq clear", irq_special, 0);
        check("R11 no insert", tx_ins_valid, 0);
        tx_boundary = 1; tx_data_avail = 1; #1;
        check("R11 not stopped", tx_start_data, 1);
        tx_boundary = 0; tx_data_avail = 0;
    endtask

    task automatic t_manual_rts();
        defaults(); settle();
        mcr_rts = 1; #1;
        check("R2 manual assert", rts_n, 0);
        cfg_auto_rts = 1; mcr_rts = 0; #1;
        check("R2 auto overrides manual", rts_n, 0);
    endtask

    task automatic t_hyst();
        defaults(); cfg_auto_rts = 1; mcr_rts = 1; settle();
        set_level(8'd99);  check("R1 below upper", rts_n, 0);
        set_level(8'd100); check("R1 at upper", rts_n, 1);
        set_level(8'd60);  check("R1 inside band", rts_n, 1);
        set_level(8'd40);  check("R1 at lower", rts_n, 1);
        set_level(8'd39);  check("R1 below lower", rts_n, 0);
    endtask

    task automatic t_dtr();
        defaults(); cfg_auto_dtr = 1; mcr_rts = 1; mcr_dtr = 1; settle();
        set_level(8'd100);
        check("R3 dtr throttled", dtr_n, 1);
        check("R3 rts stays manual", rts_n, 0);
        set_level(8'd0);
        check("R3 dtr released", dtr_n, 0);
        cfg_auto_dtr = 0; mcr_dtr = 0; #1;
        check("R3 dtr manual", dtr_n, 1);
    endtask

    task automatic t_cts();
        defaults(); settle();
        tx_boundary = 1; tx_data_avail = 1; cfg_auto_cts = 1; cts_n = 1; #1;
        check("R4 cts blocks", tx_start_data, 0);
        cfg_auto_cts = 0; #1;
        check("R4 cts ignored when off", tx_start_data, 1);
        cfg_auto_dsr = 1; dsr_n = 1; #1;
        check("R4 dsr blocks", tx_start_data, 0);
        dsr_n = 0; tx_boundary = 0; #1;
        check("R4 no start mid-character", tx_start_data, 0);
    endtask

    task automatic t_inband();
        defaults(); cfg_inband_rx = 1; settle();
        tx_boundary = 1; tx_data_avail = 1;
        send_rx(8'h13);
        check("R5 xoff stops", tx_start_data, 0);
        check("R7 xoff irq", irq_special, 1);
        send_rx(8'h41);
        check("R5 plain char keeps stop", tx_start_data, 0);
        send_rx(8'h11);
        check("R5 xon resumes", tx_start_data, 1);
        pulse_isr();
        check("R7 isr read clears", irq_special, 0);
    endtask

    task automatic t_special();
        defaults(); cfg_special_en = 1; settle();
        tx_boundary = 1; tx_data_avail = 1;
        send_rx(8'h13);
        check("R7 xoff without inband no irq", irq_special, 0);
        send_rx(8'h7E);
        check("R7 special char irq", irq_special, 1);
        check("R7 special does not stop", tx_start_data, 1);
        pulse_isr();
        check("R7 special cleared", irq_special, 0);
    endtask

    task automatic t_xon_any();
        defaults(); cfg_inband_rx = 1; cfg_xon_any = 1; settle();
        tx_boundary = 1; tx_data_avail = 1;
        send_rx(8'h13);
        check("R6 stopped first", tx_start_data, 0);
        send_rx(8'h55);
        check("R6 any char resumes", tx_start_data, 1);
    endtask

    task automatic t_insert();
        defaults(); cfg_inband_tx = 1; tx_data_avail = 1; settle();
        @(negedge clk); rx_level = 8'd100;
        @(negedge clk);
        @(negedge clk); tx_boundary = 1; #1;
        check("R8 xoff offered", tx_ins_valid, 1);
        check("R8 xoff char", tx_ins_char, 8'h13);
        check("R8 data yields", tx_start_data, 0);
        @(negedge clk); #1;
        check("R8 insert done", tx_ins_valid, 0);
        check("R8 data after insert", tx_start_data, 1);
        tx_boundary = 0;
        @(negedge clk); rx_level = 8'd10;
        @(negedge clk);
        @(negedge clk); tx_boundary = 1; #1;
        check("R8 xon offered", tx_ins_valid, 1);
        check("R8 xon char", tx_ins_char, 8'h11);
    endtask

    task automatic t_rs485();
        defaults(); cfg_rs485 = 1; settle(); #1;
        check("R9 driver off idle", dtr_n, 1);
        @(negedge clk); tx_boundary = 1; tx_data_avail = 1; tx_empty = 0; sout_idle = 0;
        @(negedge clk); tx_boundary = 0; #1;
        check("R9 driver on", dtr_n, 0);
        tx_empty = 1;
        @(negedge clk); #1;
        check("R9 held until line idle", dtr_n, 0);
        sout_idle = 1;
        @(negedge clk); #1;
        check("R9 driver released", dtr_n, 1);
    endtask

    task automatic t_loop();
        defaults(); cfg_loopback = 1; cfg_auto_rts = 1; mcr_rts = 1; mcr_dtr = 1; settle();
        set_level(8'd100);
        check("R10 status shows throttle", rx_held_off, 1);
        check("R10 rts pin inactive", rts_n, 1);
        check("R10 dtr pin inactive", dtr_n, 1);
        set_level(8'd0);
        check("R10 status released", rx_held_off, 0);
        check("R10 rts pin still inactive", rts_n, 1);
        cfg_loopback = 0; cfg_auto_rts = 0; mcr_rts = 0; #1;
        check("R10 normal status follows pin", rx_held_off, 1);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_manual_rts();
        t_hyst();
        t_dtr();
        t_cts();
        t_inband();
        t_special();
        t_xon_any();
        t_insert();
        t_rs485();
        t_loop();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule